// File: doc/BRIEF.md
# Hot-Plug Slot Power Sequencer

This block runs the power, reference-clock and reset sequence for one hot-pluggable downstream slot. A power-up request is honoured only while the slot holds a card, software asks for power and the upstream reset is released. When all three hold, the block raises its power-enable output. It then waits for the power-good input and counts a first millisecond delay. After that delay it enables the reference clock. A second millisecond delay follows, and at its end the block lets go of the active-low slot reset.

Three events trigger power-down: software drops its power request, the upstream reset asserts, or the card is pulled without warning. All three take the same teardown path. Slot reset asserts at once. The reference clock keeps running for a short parameterised delay and then stops. Power-enable is withdrawn one cycle after the clock stops. A trigger that arrives partway through power-up abandons that sequence and goes straight to teardown.

After reset is released, a configuration bit can let the slot's active-low clock-request input gate the reference clock. All delays count a one-millisecond tick input. Each delay is a parameter, so a simulation can use short values.

Top module: `hp_slot_seq`

## Requirements
- R1: While rst_n is low, pwr_en, refclk_en and slot_rst_n are all 0.
- R2: From the idle state, when pwr_ctl=1, up_rst_n=1 and prsnt_n=0, pwr_en goes to 1 on the next clock edge. At that moment refclk_en is 0 and slot_rst_n is 0.
- R3: The first delay counts only ms_tick pulses seen while pwr_good=1. A tick seen while pwr_good=0 is discarded. refclk_en rises one cycle after the PWR_WAIT_MS-th counted tick. When pwr_good is tied high, counting starts as soon as pwr_en rises.
- R4: slot_rst_n rises one cycle after the RST_WAIT_MS-th tick counted from the rise of refclk_en. Before that, slot_rst_n stays 0.
- R5: While slot_rst_n=1, clkreq_en=1 makes refclk_en equal to the inverse of clkreq_n, so the clock runs only while the request is low. clkreq_en=0 holds refclk_en at 1.
- R6: While the slot is running, any of pwr_ctl=0, up_rst_n=0 or prsnt_n=1 drives slot_rst_n to 0 on the next edge. refclk_en is 1 after that edge, whatever clkreq_n is.
- R7: After a teardown starts with the clock running, refclk_en stays 1 for CLK_STOP_MS ticks and then falls. pwr_en falls on the edge after refclk_en falls.
- R8: While prsnt_n=1, the block ignores a power request: pwr_en stays 0.
- R9: A trigger that arrives while the block waits for the first delay removes pwr_en two cycles later, and refclk_en never rises. A trigger that arrives during the second delay leaves slot_rst_n at 0 and runs the R7 clock-stop delay.
- R10: slot_rst_n=1 and refclk_en=1 each occur only while pwr_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| pwr_ctl | input | 1 | Software power request, 1 = power the slot |
| up_rst_n | input | 1 | Upstream reset, active low |
| prsnt_n | input | 1 | Card presence, active low |
| pwr_good | input | 1 | Slot power valid, tie high when no feedback exists |
| clkreq_n | input | 1 | Clock request from the card, active low |
| clkreq_en | input | 1 | Configuration: 1 = let clkreq_n gate the clock after reset release |
| pwr_en | output | 1 | Slot power switch enable |
| refclk_en | output | 1 | Reference clock enable |
| slot_rst_n | output | 1 | Slot reset, active low |

## Verification
Two of the block's functions can land on the same cycle: the clock-request gate and a power-down trigger. The bench drives clkreq_n high and clears pwr_ctl on the same edge while the slot is running. It expects the teardown to win. Reset must drop while the clock stays on, and the full clock-stop delay must follow. A second collision puts a millisecond tick on the same edge as a state change. The scoreboard counts ticks between output changes, so a tick that was wrongly credited to the new state shows up as a count mismatch.

// File: rtl/hp_seq_pkg.sv
package hp_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PWR   = 3'd1,
    ST_REF   = 3'd2,
    ST_RUN   = 3'd3,
    ST_TDCLK = 3'd4,
    ST_TDPWR = 3'd5
  } seq_st_e;

  // All three conditions needed to hold the slot powered
  function automatic logic slot_up_req(input logic pwr_ctl,
                                       input logic up_rst_n,
                                       input logic prsnt_n);
    return pwr_ctl & up_rst_n & ~prsnt_n;
  endfunction

  // Millisecond count the current state waits for
  function automatic int unsigned wait_for_state(input seq_st_e st,
                                                 input int unsigned pwr_ms,
                                                 input int unsigned rst_ms,
                                                 input int unsigned stop_ms);
    case (st)
      ST_PWR:   return pwr_ms;
      ST_REF:   return rst_ms;
      ST_TDCLK: return stop_ms;
      default:  return 0;
    endcase
  endfunction

  // Clock enable once the slot runs
  function automatic logic run_clk(input logic clkreq_en, input logic clkreq_n);
    return ~(clkreq_en & clkreq_n);
  endfunction

endpackage

// File: rtl/hp_ms_timer.sv
module hp_ms_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr)          cnt_q <= '0;
    else if (tick && !done) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hp_seq_fsm.sv
module hp_seq_fsm
  import hp_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    up_req,
  input  logic    tmr_done,
  output seq_st_e st,
  output logic    st_chg
);
  seq_st_e nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF:   if (up_req) nxt = ST_PWR;
      ST_PWR:   if (!up_req) nxt = ST_TDPWR;
                else if (tmr_done) nxt = ST_REF;
      ST_REF:   if (!up_req) nxt = ST_TDCLK;
                else if (tmr_done) nxt = ST_RUN;
      ST_RUN:   if (!up_req) nxt = ST_TDCLK;
      ST_TDCLK: if (tmr_done) nxt = ST_TDPWR;
      ST_TDPWR: nxt = ST_OFF;
      default:  nxt = ST_OFF;
    endcase
  end

  assign st_chg = (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= nxt;
  end
endmodule

// File: rtl/hp_clk_gate.sv
module hp_clk_gate
  import hp_seq_pkg::*;
(
  input  seq_st_e st,
  input  logic    clkreq_en,
  input  logic    clkreq_n,
  output logic    pwr_en,
  output logic    refclk_en,
  output logic    slot_rst_n
);
  always_comb begin
    pwr_en     = (st != ST_OFF);
    slot_rst_n = (st == ST_RUN);
    case (st)
      ST_REF, ST_TDCLK: refclk_en = 1'b1;
      ST_RUN:           refclk_en = run_clk(clkreq_en, clkreq_n);
      default:          refclk_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/hp_slot_seq.sv
module hp_slot_seq
  import hp_seq_pkg::*;
#(
  parameter int unsigned PWR_WAIT_MS = 100,
  parameter int unsigned RST_WAIT_MS = 100,
  parameter int unsigned CLK_STOP_MS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pwr_ctl,
  input  logic up_rst_n,
  input  logic prsnt_n,
  input  logic pwr_good,
  input  logic clkreq_n,
  input  logic clkreq_en,
  output logic pwr_en,
  output logic refclk_en,
  output logic slot_rst_n
);
  localparam int unsigned MAX_A  = (PWR_WAIT_MS > RST_WAIT_MS) ? PWR_WAIT_MS : RST_WAIT_MS;
  localparam int unsigned MAX_MS = (MAX_A > CLK_STOP_MS) ? MAX_A : CLK_STOP_MS;
  localparam int          CNT_W  = $clog2(MAX_MS + 1) + 1;

  seq_st_e          st;
  logic             st_chg;
  logic             up_evt;
  logic             down_evt;
  logic             tmr_run;
  logic             tmr_clr;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_limit;

  assign up_evt    = slot_up_req(pwr_ctl, up_rst_n, prsnt_n);
  assign down_evt  = ~up_evt;
  assign tmr_run   = (st != ST_PWR) || pwr_good;
  assign tmr_clr   = st_chg || !tmr_run;
  assign tmr_limit = CNT_W'(wait_for_state(st, PWR_WAIT_MS, RST_WAIT_MS, CLK_STOP_MS));

  hp_seq_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_req   (up_evt),
    .tmr_done (tmr_done),
    .st       (st),
    .st_chg   (st_chg)
  );

  hp_ms_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .tick  (ms_tick),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  hp_clk_gate gate_i (
    .st         (st),
    .clkreq_en  (clkreq_en),
    .clkreq_n   (clkreq_n),
    .pwr_en     (pwr_en),
    .refclk_en  (refclk_en),
    .slot_rst_n (slot_rst_n)
  );
endmodule

// File: rtl/hp_slot_seq_chk.sv
module hp_slot_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_en,
  input logic refclk_en,
  input logic slot_rst_n,
  input logic prsnt_n,
  input logic down_evt,
  input logic clkreq_n,
  input logic clkreq_en
);
  // R10
  rst_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rst_n |-> pwr_en);
  // R10
  clk_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refclk_en |-> pwr_en);
  // R2
  start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (!refclk_en && !slot_rst_n));
  // R4
  release_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_rst_n) |-> $past(refclk_en));
  // R5
  clkreq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_rst_n && clkreq_en) |-> (refclk_en == !clkreq_n));
  // R6
  trigger_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_rst_n && down_evt) |=> (!slot_rst_n && refclk_en));
  // R7
  pwr_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> (!refclk_en && $past(!refclk_en)));
  // R8
  absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && prsnt_n) |=> !pwr_en);
endmodule

bind hp_slot_seq hp_slot_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_en     (pwr_en),
  .refclk_en  (refclk_en),
  .slot_rst_n (slot_rst_n),
  .prsnt_n    (prsnt_n),
  .down_evt   (down_evt),
  .clkreq_n   (clkreq_n),
  .clkreq_en  (clkreq_en)
);

// File: tb/hp_slot_seq_tb.sv
module hp_slot_seq_tb_top;
  localparam int CLK_PER = 10;
  localparam int T_PWR   = 5;
  localparam int T_RST   = 4;
  localparam int T_STOP  = 2;

  logic clk = 0, rst_n = 0, ms_tick = 0;
  logic pwr_ctl = 0, up_rst_n = 1, prsnt_n = 0, pwr_good = 1;
  logic clkreq_n = 0, clkreq_en = 0;
  logic pwr_en, refclk_en, slot_rst_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] o;
    int         tk;
    string      rq;
  } exp_t;
  exp_t q[$];

  always #(CLK_PER/2) clk = ~clk;

  hp_slot_seq #(.PWR_WAIT_MS(T_PWR), .RST_WAIT_MS(T_RST), .CLK_STOP_MS(T_STOP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_ctl(pwr_ctl),
    .up_rst_n(up_rst_n), .prsnt_n(prsnt_n), .pwr_good(pwr_good),
    .clkreq_n(clkreq_n), .clkreq_en(clkreq_en),
    .pwr_en(pwr_en), .refclk_en(refclk_en), .slot_rst_n(slot_rst_n)
  );

  // expected output vector {pwr_en, refclk_en, slot_rst_n}, ticks since last change (-1 = any)
  task automatic expect_o(input logic [2:0] o, input int tk, input string rq);
    exp_t e;
    e.o = o; e.tk = tk; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic chk_val(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      ms_tick = 1; @(negedge clk);
      ms_tick = 0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: pops one item per output change and compares value and tick spacing
  initial begin
    logic [2:0] prev, cur;
    int tcnt;
    exp_t e;
    prev = 3'b000; tcnt = 0;
    wait (rst_n);
    forever begin
      @(posedge clk); #1;
      cur = {pwr_en, refclk_en, slot_rst_n};
      if (cur !== prev) begin
        n_chk++;
        if (q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected change actual=%b expected=%b", cur, prev);
        end else begin
          e = q.pop_front();
          if (cur !== e.o || (e.tk >= 0 && tcnt != e.tk)) begin
            n_bad++;
            $display("FAIL %s actual=%b/%0d ticks expected=%b/%0d ticks",
                     e.rq, cur, tcnt, e.o, e.tk);
          end
        end
        tcnt = 0;
        prev = cur;
      end else begin
        tcnt += int'(ms_tick);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(4);
    // R1: outputs low during reset
    chk_val("R1", int'({pwr_en, refclk_en, slot_rst_n}), 0);
    rst_n = 1;
    step(2);

    // normal power-up, pwr_good tied high
    expect_o(3'b100, -1, "R2");
    expect_o(3'b110, T_PWR, "R3");
    expect_o(3'b111, T_RST, "R4");
    pwr_ctl = 1; step(2);
    ticks(T_PWR); ticks(T_RST); step(3);
    chk_val("R4", int'(slot_rst_n), 1);

    // R5: clock request ignored while gating disabled
    clkreq_n = 1; step(6);
    chk_val("R5", int'(refclk_en), 1);
    chk_val("R5", q.size(), 0);
    expect_o(3'b101, -1, "R5");
    clkreq_en = 1; step(3);
    expect_o(3'b111, -1, "R5");
    clkreq_n = 0; step(3);

    // software power-down
    expect_o(3'b110, -1, "R6");
    expect_o(3'b100, T_STOP, "R7");
    expect_o(3'b000, 0, "R7");
    pwr_ctl = 0; step(3); ticks(T_STOP); step(3);

    // R8: request with card absent
    prsnt_n = 1; pwr_ctl = 1; step(10); ticks(2);
    chk_val("R8", int'({pwr_en, refclk_en, slot_rst_n}), 0);
    chk_val("R8", q.size(), 0);

    // R3 power-good wait, then R9 abort during second delay by upstream reset
    pwr_good = 0;
    expect_o(3'b100, -1, "R2");
    expect_o(3'b110, 3 + T_PWR, "R3");
    expect_o(3'b100, 2 + T_STOP, "R9");
    expect_o(3'b000, 0, "R9");
    prsnt_n = 0; step(3); ticks(3);
    pwr_good = 1; ticks(T_PWR);
    ticks(2); up_rst_n = 0; step(2); ticks(T_STOP); step(4);

    // R9: abort during first delay by removal
    expect_o(3'b100, -1, "R2");
    expect_o(3'b000, 2, "R9");
    up_rst_n = 1; step(3); ticks(2);
    prsnt_n = 1; step(4);
    chk_val("R9", int'(pwr_en), 0);

    // concurrent clock request drop and software power-down in run state
    clkreq_en = 1; clkreq_n = 0;
    expect_o(3'b100, -1, "R2");
    expect_o(3'b110, T_PWR, "R3");
    expect_o(3'b111, T_RST, "R4");
    prsnt_n = 0; step(2); ticks(T_PWR); ticks(T_RST); step(2);
    expect_o(3'b110, -1, "R6");
    expect_o(3'b100, T_STOP, "R7");
    expect_o(3'b000, 0, "R7");
    clkreq_n = 1; pwr_ctl = 0; step(3); ticks(T_STOP); step(3);

    // surprise removal from run state
    clkreq_n = 0;
    expect_o(3'b100, -1, "R2");
    expect_o(3'b110, T_PWR, "R3");
    expect_o(3'b111, T_RST, "R4");
    pwr_ctl = 1; step(2); ticks(T_PWR); ticks(T_RST); step(2);
    expect_o(3'b110, -1, "R6");
    expect_o(3'b100, T_STOP, "R7");
    expect_o(3'b000, 0, "R7");
    prsnt_n = 1; step(3); ticks(T_STOP); step(4);

    chk_val("R7", q.size(), 0);
    chk_val("R10", int'({pwr_en, refclk_en, slot_rst_n}), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule